// File: doc/BRIEF.md
# Partitioned Flash Status Register Unit

This block keeps the program/erase status of a flash device that is split into several partitions. Each partition has its own six flag bits: erase suspended, erase error, program error, low-voltage abort, program suspended and locked-block abort. One ready/busy bit is shared by the whole device. The unit also records which partition currently owns the write engine. The write state machine reports its activity as one-cycle event strobes. Each strobe carries a partition index, and a clear-status command is addressed the same way.

The read port gives a single-word view of one partition's status. Bit 0 of that word is computed when the word is read, not stored. While the device is busy, bit 0 tells whether the partition being read is the busy one (0) or a different one (1). The read word is captured when output enable or chip enable falls. It then stays fixed until the next such fall, even if status changes in the meantime. Bits 15:8 of the data bus are always zero.

Top module: `part_status_unit`

## Requirements
- R1: After reset every partition's flags (bits 6..1) are 0, the device is ready, and `rd_data` is 0.
- R2: A captured word is {8'h00, ready, erase-suspended, erase-error, program-error, low-voltage, program-suspended, lock-abort, bit0}, with ready at bit 7 and the flags in bits 6 down to 1.
- R3: `ev_start` makes the device busy (bit 7 = 0) and records `ev_part` as the busy partition. `ev_done` makes the device ready again.
- R4: While busy, bit 0 reads 0 for the busy partition and 1 for every other partition. While ready, bit 0 reads 0.
- R5: `ev_pgm_fail` sets bit 4 and `ev_ers_fail` sets bit 5. Each affects only the partition given by `ev_part`.
- R6: `ev_seq_err` sets bits 5 and 4 of the tagged partition and makes the device ready.
- R7: `ev_susp_ers` sets bit 6 of the tagged partition and makes the device ready. `ev_resume` clears bit 6 and makes the device busy again, with the busy partition unchanged.
- R8: `ev_susp_pgm` sets bit 2 and makes the device ready. `ev_resume` clears bit 2 and makes the device busy again.
- R9: `ev_lock_viol` while `wr_prot_n` is 0 sets bit 1 of the tagged partition and makes the device ready. While `wr_prot_n` is 1 it has no effect.
- R10: `ev_low_vpp` sets bit 3 only in a cycle where `ev_done` is also high. On its own it has no effect.
- R11: `clr_status` clears bits 5, 4, 3 and 1 of the partition given by `ev_part`. Bit 7, both suspend bits and the other partitions keep their values. A set event in the same cycle wins.
- R12: `rd_data` is loaded on the clock after `oe_n` or `ce_n` is seen to go from 1 to 0, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_part | input | PIDX_W | Partition tag for events and clear |
| ev_start | input | 1 | Program/erase started |
| ev_done | input | 1 | Program/erase finished |
| ev_pgm_fail | input | 1 | Word program failed |
| ev_ers_fail | input | 1 | Erase failed |
| ev_susp_ers | input | 1 | Erase suspended |
| ev_susp_pgm | input | 1 | Program suspended |
| ev_resume | input | 1 | Suspended operation resumed |
| ev_lock_viol | input | 1 | Operation aimed at a locked block |
| ev_low_vpp | input | 1 | Programming voltage low at completion |
| ev_seq_err | input | 1 | Command sequence error |
| clr_status | input | 1 | Clear error flags of tagged partition |
| wr_prot_n | input | 1 | Write protect, low = protection active |
| rd_part | input | PIDX_W | Partition whose status is read |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| rd_data | output | 16 | Captured status word |

## Verification
The hardest state to reach is a resumed operation: busy must return with the original owner still recorded, so that bit 0 differs between partitions. Clearing must also not touch the suspend flag. The bench reaches this with start, suspend, clear and resume on one partition, then reads that partition and a neighbour. A second hard case is a status change between two captures. The bench captures with output enable, injects a failure while both strobes stay put, and then recaptures through chip enable alone.

// File: rtl/pstat_pkg.sv
`timescale 1ns/1ps
package pstat_pkg;

  // Per-partition flags, packed so that bit 5 of the struct is status bit 6
  typedef struct packed {
    logic ers_susp;   // status bit 6
    logic ers_err;    // status bit 5
    logic pgm_err;    // status bit 4
    logic vpp_low;    // status bit 3
    logic pgm_susp;   // status bit 2
    logic lock_abort; // status bit 1
  } pflags_t;

  // Qualified events as seen by one partition
  typedef struct packed {
    logic susp_ers;
    logic susp_pgm;
    logic resume;
    logic pgm_fail;
    logic ers_fail;
    logic seq_err;
    logic lock_q;
    logic vpp_q;
    logic clr;
  } pev_t;

  function automatic pflags_t flag_update(input pflags_t cur, input pev_t e);
    pflags_t n;
    n = cur;
    if (e.clr) begin
      n.ers_err    = 1'b0;
      n.pgm_err    = 1'b0;
      n.vpp_low    = 1'b0;
      n.lock_abort = 1'b0;
    end
    if (e.resume)   begin n.ers_susp = 1'b0; n.pgm_susp = 1'b0; end
    if (e.susp_ers) n.ers_susp   = 1'b1;
    if (e.susp_pgm) n.pgm_susp   = 1'b1;
    if (e.ers_fail | e.seq_err) n.ers_err = 1'b1;
    if (e.pgm_fail | e.seq_err) n.pgm_err = 1'b1;
    if (e.vpp_q)    n.vpp_low    = 1'b1;
    if (e.lock_q)   n.lock_abort = 1'b1;
    return n;
  endfunction

  function automatic logic ready_update(input logic cur, input logic start,
                                        input logic to_ready, input logic resume);
    if (start)         return 1'b0;
    else if (to_ready) return 1'b1;
    else if (resume)   return 1'b0;
    return cur;
  endfunction

  function automatic logic [7:0] compose_status(input logic ready, input pflags_t f,
                                                input logic reads_other);
    return {ready, f, (~ready) & reads_other};
  endfunction

endpackage

// File: rtl/pstat_bank.sv
`timescale 1ns/1ps
module pstat_bank
  import pstat_pkg::*;
#(
  parameter int NPART  = 4,
  parameter int PIDX_W = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIDX_W-1:0] ev_part,
  input  pev_t              ev,
  output pflags_t           flags_o [NPART]
);

  for (genvar i = 0; i < NPART; i++) begin : g_part
    logic    hit;
    pflags_t flags_q;
    assign hit = (ev_part == PIDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   flags_q <= '0;
      else if (hit) flags_q <= flag_update(flags_q, ev);
    end
    assign flags_o[i] = flags_q;
  end

endmodule

// File: rtl/pstat_device.sv
`timescale 1ns/1ps
module pstat_device
  import pstat_pkg::*;
#(
  parameter int PIDX_W = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIDX_W-1:0] ev_part,
  input  logic              start,
  input  logic              to_ready,
  input  logic              resume,
  output logic              ready_o,
  output logic [PIDX_W-1:0] owner_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_o <= 1'b1;
      owner_o <= '0;
    end else begin
      ready_o <= ready_update(ready_o, start, to_ready, resume);
      if (start) owner_o <= ev_part;
    end
  end

endmodule

// File: rtl/pstat_readport.sv
`timescale 1ns/1ps
module pstat_readport #(
  parameter int DBUS_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_n,
  input  logic              ce_n,
  input  logic [7:0]        status,
  output logic              cap_evt,
  output logic [DBUS_W-1:0] rd_data
);

  logic oe_d, ce_d;

  assign cap_evt = (oe_d & ~oe_n) | (ce_d & ~ce_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_d    <= 1'b1;
      ce_d    <= 1'b1;
      rd_data <= '0;
    end else begin
      oe_d <= oe_n;
      ce_d <= ce_n;
      if (cap_evt) rd_data <= {{(DBUS_W-8){1'b0}}, status};
    end
  end

endmodule

// File: rtl/part_status_unit.sv
`timescale 1ns/1ps
module part_status_unit
  import pstat_pkg::*;
#(
  parameter  int NPART  = 4,
  localparam int PIDX_W = (NPART > 1) ? $clog2(NPART) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIDX_W-1:0] ev_part,
  input  logic              ev_start,
  input  logic              ev_done,
  input  logic              ev_pgm_fail,
  input  logic              ev_ers_fail,
  input  logic              ev_susp_ers,
  input  logic              ev_susp_pgm,
  input  logic              ev_resume,
  input  logic              ev_lock_viol,
  input  logic              ev_low_vpp,
  input  logic              ev_seq_err,
  input  logic              clr_status,
  input  logic              wr_prot_n,
  input  logic [PIDX_W-1:0] rd_part,
  input  logic              oe_n,
  input  logic              ce_n,
  output logic [15:0]       rd_data
);

  pev_t              ev;
  pflags_t           flags [NPART];
  pflags_t           sel_flags;
  logic              dev_ready;
  logic [PIDX_W-1:0] owner;
  logic              to_ready;
  logic              cap_evt;
  logic [7:0]        status_now;

  assign ev.susp_ers = ev_susp_ers;
  assign ev.susp_pgm = ev_susp_pgm;
  assign ev.resume   = ev_resume;
  assign ev.pgm_fail = ev_pgm_fail;
  assign ev.ers_fail = ev_ers_fail;
  assign ev.seq_err  = ev_seq_err;
  assign ev.lock_q   = ev_lock_viol & ~wr_prot_n;
  assign ev.vpp_q    = ev_low_vpp & ev_done;
  assign ev.clr      = clr_status;

  assign to_ready = ev_done | ev_susp_ers | ev_susp_pgm | ev_seq_err | ev.lock_q;

  pstat_bank #(.NPART(NPART), .PIDX_W(PIDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .ev_part(ev_part), .ev(ev), .flags_o(flags)
  );

  pstat_device #(.PIDX_W(PIDX_W)) u_dev (
    .clk(clk), .rst_n(rst_n), .ev_part(ev_part), .start(ev_start),
    .to_ready(to_ready), .resume(ev_resume), .ready_o(dev_ready), .owner_o(owner)
  );

  always_comb begin
    sel_flags = '0;
    for (int k = 0; k < NPART; k++)
      if (rd_part == PIDX_W'(k)) sel_flags = flags[k];
  end

  assign status_now = compose_status(dev_ready, sel_flags, rd_part != owner);

  pstat_readport #(.DBUS_W(16)) u_rd (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ce_n(ce_n),
    .status(status_now), .cap_evt(cap_evt), .rd_data(rd_data)
  );

endmodule

// File: rtl/pstat_checker.sv
`timescale 1ns/1ps
module pstat_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_start,
  input logic        ev_done,
  input logic        ev_seq_err,
  input logic        ev_susp_ers,
  input logic        ev_susp_pgm,
  input logic        dev_ready,
  input logic        cap_evt,
  input logic [15:0] rd_data
);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:8] == 8'h00);

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !dev_ready);

  assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !ev_start) |=> dev_ready);

  assert_bit0_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |-> !rd_data[0]);

  assert_seqerr_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_seq_err && !ev_start) |=> dev_ready);

  assert_susp_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_susp_ers || ev_susp_pgm) && !ev_start) |=> dev_ready);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(rd_data));

endmodule

bind part_status_unit pstat_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_done(ev_done),
  .ev_seq_err(ev_seq_err), .ev_susp_ers(ev_susp_ers), .ev_susp_pgm(ev_susp_pgm),
  .dev_ready(dev_ready), .cap_evt(cap_evt), .rd_data(rd_data)
);

// File: tb/test_part_status_unit.sv
`timescale 1ns/1ps
module test_part_status_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ev_part = '0;
  logic ev_start = 0, ev_done = 0, ev_pgm_fail = 0, ev_ers_fail = 0;
  logic ev_susp_ers = 0, ev_susp_pgm = 0, ev_resume = 0, ev_lock_viol = 0;
  logic ev_low_vpp = 0, ev_seq_err = 0, clr_status = 0, wr_prot_n = 1;
  logic [1:0] rd_part = '0;
  logic oe_n = 1, ce_n = 1;
  logic [15:0] rd_data;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  part_status_unit #(.NPART(4)) i_part_status_unit (
    .clk(clk), .rst_n(rst_n), .ev_part(ev_part), .ev_start(ev_start), .ev_done(ev_done),
    .ev_pgm_fail(ev_pgm_fail), .ev_ers_fail(ev_ers_fail), .ev_susp_ers(ev_susp_ers),
    .ev_susp_pgm(ev_susp_pgm), .ev_resume(ev_resume), .ev_lock_viol(ev_lock_viol),
    .ev_low_vpp(ev_low_vpp), .ev_seq_err(ev_seq_err), .clr_status(clr_status),
    .wr_prot_n(wr_prot_n), .rd_part(rd_part), .oe_n(oe_n), .ce_n(ce_n), .rd_data(rd_data)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(input string name, input int p);
    @(negedge clk);
    ev_part = 2'(p);
    case (name)
      "start": ev_start = 1;     "done": ev_done = 1;
      "pfail": ev_pgm_fail = 1;  "efail": ev_ers_fail = 1;
      "se":    ev_susp_ers = 1;  "sp":   ev_susp_pgm = 1;
      "res":   ev_resume = 1;    "lock": ev_lock_viol = 1;
      "vpp":   ev_low_vpp = 1;   "seq":  ev_seq_err = 1;
      "clr":   clr_status = 1;
      "donevpp": begin ev_done = 1; ev_low_vpp = 1; end
      default: ;
    endcase
    @(negedge clk);
    {ev_start, ev_done, ev_pgm_fail, ev_ers_fail, ev_susp_ers, ev_susp_pgm,
     ev_resume, ev_lock_viol, ev_low_vpp, ev_seq_err, clr_status} = '0;
  endtask

  // capture through a falling output enable and compare the word
  task automatic rd(input int p, input logic [7:0] exp, input string tag);
    rd_part = 2'(p);
    oe_n = 0;
    @(negedge clk);
    check(rd_data, {8'h00, exp}, tag);
    oe_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(rd_data, 16'h0000, "R1 rd_data after reset");
    rd(0, 8'h80, "R1 R2 idle partition 0");
    rd(3, 8'h80, "R1 idle partition 3");
  endtask

  task automatic t_busy;
    pulse("start", 2);
    rd(2, 8'h00, "R3 R4 busy partition reads bit0=0");
    rd(1, 8'h01, "R4 other partition reads bit0=1");
    pulse("done", 2);
    rd(2, 8'h80, "R3 done restores ready");
    rd(1, 8'h80, "R4 bit0 zero when ready");
  endtask

  task automatic t_fail_clear;
    pulse("pfail", 1);
    pulse("efail", 3);
    rd(1, 8'h90, "R5 program fail bit4");
    rd(3, 8'hA0, "R5 erase fail bit5");
    rd(0, 8'h80, "R5 untagged partition untouched");
    pulse("clr", 1);
    rd(1, 8'h80, "R11 clear partition 1");
    rd(3, 8'hA0, "R11 other partition keeps error");
    pulse("clr", 3);
    rd(3, 8'h80, "R11 clear partition 3");
  endtask

  task automatic t_seq;
    pulse("start", 0);
    pulse("seq", 0);
    rd(0, 8'hB0, "R6 sequence error sets 7,5,4");
    pulse("clr", 0);
    rd(0, 8'h80, "R6 R11 cleared");
  endtask

  task automatic t_susp;
    pulse("start", 3);
    pulse("se", 3);
    rd(3, 8'hC0, "R7 erase suspend");
    pulse("clr", 3);
    rd(3, 8'hC0, "R11 clear keeps suspend and ready");
    pulse("res", 3);
    rd(3, 8'h00, "R7 resume busy again, owner");
    rd(2, 8'h01, "R7 resume owner unchanged");
    pulse("done", 3);
    pulse("start", 1);
    pulse("sp", 1);
    rd(1, 8'h84, "R8 program suspend");
    pulse("res", 1);
    rd(1, 8'h00, "R8 resume clears bit2");
    pulse("done", 1);
    rd(1, 8'h80, "R8 done after resume");
  endtask

  task automatic t_lock_vpp;
    wr_prot_n = 1;
    pulse("lock", 2);
    rd(2, 8'h80, "R9 lock ignored while unprotected");
    wr_prot_n = 0;
    pulse("start", 2);
    pulse("lock", 2);
    rd(2, 8'h82, "R9 lock abort bit1 and ready");
    pulse("clr", 2);
    wr_prot_n = 1;
    pulse("vpp", 0);
    rd(0, 8'h80, "R10 low voltage alone ignored");
    pulse("start", 0);
    pulse("donevpp", 0);
    rd(0, 8'h88, "R10 low voltage at completion");
    pulse("clr", 0);
    rd(0, 8'h80, "R11 clear bit3");
  endtask

  task automatic t_hold;
    rd(0, 8'h80, "R12 capture before change");
    pulse("pfail", 0);
    check(rd_data, 16'h0080, "R12 held without falling edge");
    ce_n = 0;
    @(negedge clk);
    check(rd_data, 16'h0090, "R12 chip enable recapture");
    ce_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_busy;
    t_fail_clear;
    t_seq;
    t_susp;
    t_lock_vpp;
    t_hold;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule